// File: doc/BRIEF.md
# DDR Write Data Launch Scheduler

This block decides, for each write burst of a DDR SDRAM controller, the exact phase tick at which the data strobe enable, the data-valid flag, the data beats and the mask beats go out, measured from the tick at which the write command itself is launched. It runs on a phase clock at four times the memory clock, so every delay it applies can be placed in quarter-clock steps. Write requests arrive as one command strobe carrying a whole four-beat burst of data and mask. They wait in a small two-entry queue until the previous burst has fully drained.

The launch point is measured from the memory-clock edge one clock after the command. Two configuration inputs shift it. A registered-module flag adds one whole memory clock, because such modules latch their control signals before using them. A 3-bit delay field adds 0 to 7 quarter-clock steps. Before the first beat the strobe enable opens one memory clock early as a preamble. It closes half a clock after the last beat as a postamble. A registered flag reports whether the programmed quarter-step delay, plus a fixed board skew, puts the strobe at the memory between 0.75 and 1.25 clocks after the capturing edge of the command.

Top module: `ddrw_launch_sched`

## Requirements
- R1: While reset is high and on the tick after it, `cmd_go`, `dqs_en`, `dq_valid` and `dqs_win_ok` are 0, `dq_data` and `dq_mask` are zero and `wr_ready` is 1.
- R2: `cmd_go` is a single-tick pulse that marks a command launch, and `out_phase` is 0 on that tick (a memory-clock edge).
- R3: The first tick with `dq_valid` high comes exactly 4*(1+`cfg_rdimm`)+`cfg_wdelay` ticks after the `cmd_go` tick, and `out_phase` on that tick equals that offset modulo 4.
- R4: A burst shows `dq_valid` for 8 consecutive ticks and carries beat k (k=0..3) for two ticks each, in order. Beat k is `wr_data[k*DW +: DW]` and `wr_mask[k*MW +: MW]`, so D0 is the lowest slice.
- R5: `dqs_en` rises 4 ticks before the first `dq_valid` tick, stays high through the burst, and is low again from 10 ticks after the first `dq_valid` tick.
- R6: Whenever `dq_valid` is low, `dq_data` and `dq_mask` are zero.
- R7: Up to two accepted commands wait in a queue. `wr_ready` is low while both entries are full, and bursts launch in the order they were accepted.
- R8: The configuration is sampled on the launch tick. Changes made after `cmd_go` do not move the beats of the burst already launched.
- R9: `dqs_win_ok` follows the configuration one tick later. It is 1 exactly when `cfg_wdelay` + SKEW_TICKS lies in 3..5 ticks (0.75 to 1.25 memory clocks).
- R10: A new `cmd_go` never comes before `dqs_en` of the previous burst has gone low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four ticks per memory clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write command with burst offered |
| wr_ready | output | 1 | Queue can accept a command |
| wr_data | input | 4*DW | Four data beats, D0 in the lowest slice |
| wr_mask | input | 4*MW | Four mask beats, aligned to the data beats |
| cfg_rdimm | input | 1 | Registered-module mode: one extra memory clock of delay |
| cfg_wdelay | input | 3 | Extra delay in quarter-clock steps |
| cmd_go | output | 1 | Write command launch tick |
| dqs_en | output | 1 | Data strobe enable including preamble and postamble |
| dq_valid | output | 1 | A data beat is on `dq_data` |
| dq_data | output | DW | Current data beat |
| dq_mask | output | MW | Current mask beat |
| out_phase | output | 2 | Phase tag of this tick within the memory clock |
| dqs_win_ok | output | 1 | Programmed delay lies inside the strobe arrival window |

## Verification
A directed sweep drives every delay value with the registered-module flag both clear and set. Each of those sixteen cases tells apart a whole-clock error from a quarter-step error in the first-beat tick and its phase tag, and shows whether the preamble and postamble follow the offset. Bursts whose four beats all differ show beat order and mask alignment. Four back-to-back commands fill the queue and show the ready back-pressure, launch order and the gap between bursts. A configuration change right after launch separates launch-time sampling from live use. Seeded random bursts with random settings then mix these cases.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;
  localparam int TPC    = 4;                 // phase ticks per memory clock
  localparam int BEATS  = 4;                 // beats per write burst
  localparam int WDD_W  = 3;                 // quarter-step delay field width
  localparam int PH_W   = $clog2(TPC);
  localparam int BI_W   = $clog2(BEATS);
  localparam int MAX_OFF = 2 * TPC + (1 << WDD_W) - 1;
  localparam int CNT_W  = $clog2(MAX_OFF + 2 * BEATS + 3) + 1;
  localparam int WIN_LO = (TPC * 3) / 4;     // 0.75 clock in ticks
  localparam int WIN_HI = (TPC * 5) / 4;     // 1.25 clock in ticks

  function automatic logic [CNT_W-1:0] launch_off(input logic rd,
                                                   input logic [WDD_W-1:0] w);
    logic [CNT_W-1:0] v;
    v = CNT_W'(TPC) + CNT_W'(w);
    if (rd) v = v + CNT_W'(TPC);
    return v;
  endfunction
endpackage

// File: rtl/ddrw_cmd_fifo.sv
module ddrw_cmd_fifo #(
  parameter int W     = 72,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          push, do_pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign do_pop    = pop && out_valid;
  assign out_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  q_depth_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R7
  q_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !pop) |=> !in_ready);
endmodule

// File: rtl/ddrw_seq.sv
module ddrw_seq
  import ddrw_pkg::*;
#(
  parameter int SKEW_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_valid,
  input  logic             cfg_rdimm,
  input  logic [WDD_W-1:0] cfg_wdelay,
  output logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] off,
  output logic [PH_W-1:0]  phase,
  output logic             win_ok
);
  // launch so that the registered cmd_go lands on phase 0
  localparam logic [PH_W-1:0] START_PH = PH_W'(TPC - 2);

  logic last;
  int   arrive;

  assign start  = !busy && q_valid && (phase == START_PH);
  assign last   = (cnt == off + CNT_W'(2 * BEATS + 1));
  assign arrive = int'(cfg_wdelay) + SKEW_TICKS;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      busy   <= 1'b0;
      cnt    <= '0;
      off    <= '0;
      win_ok <= 1'b0;
    end else begin
      phase  <= phase + 1'b1;
      win_ok <= (arrive >= WIN_LO) && (arrive <= WIN_HI);
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        off  <= launch_off(cfg_rdimm, cfg_wdelay);
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      cnt  <= cnt + 1'b1;
      end
    end
  end

  // R2
  launch_align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (phase == START_PH + 1'b1));
  // R8
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> $stable(off) || !busy || $rose(busy));
endmodule

// File: rtl/ddrw_out_stage.sv
module ddrw_out_stage
  import ddrw_pkg::*;
#(
  parameter int DW = 16,
  parameter int MW = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [BEATS*DW-1:0] in_data,
  input  logic [BEATS*MW-1:0] in_mask,
  input  logic                busy,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [CNT_W-1:0]    off,
  input  logic [PH_W-1:0]     phase,
  output logic                cmd_go,
  output logic                dqs_en,
  output logic                dq_valid,
  output logic [DW-1:0]       dq_data,
  output logic [MW-1:0]       dq_mask,
  output logic [PH_W-1:0]     out_phase
);
  logic [BEATS*DW-1:0] pay_d;
  logic [BEATS*MW-1:0] pay_m;
  logic [CNT_W-1:0]    rel;
  logic [BI_W-1:0]     bidx;
  logic                dv_n, dqs_n, go_n;

  always_comb begin
    rel   = cnt - off;
    bidx  = rel[BI_W:1];
    go_n  = busy && (cnt == '0);
    dv_n  = busy && (cnt >= off) && (cnt < off + CNT_W'(2 * BEATS));
    dqs_n = busy && (cnt + CNT_W'(TPC) >= off)
                 && (cnt <= off + CNT_W'(2 * BEATS + 1));
  end

  always_ff @(posedge clk) begin
    if (start) begin
      pay_d <= in_data;
      pay_m <= in_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_go    <= 1'b0;
      dqs_en    <= 1'b0;
      dq_valid  <= 1'b0;
      dq_data   <= '0;
      dq_mask   <= '0;
      out_phase <= '0;
    end else begin
      cmd_go    <= go_n;
      dqs_en    <= dqs_n;
      dq_valid  <= dv_n;
      dq_data   <= dv_n ? pay_d[bidx*DW +: DW] : '0;
      dq_mask   <= dv_n ? pay_m[bidx*MW +: MW] : '0;
      out_phase <= phase + 1'b1;
    end
  end

  // R5
  strobe_cover_chk: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> dqs_en);
  // R2
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> !cmd_go);
  // R2
  go_phase_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_go |-> (out_phase == '0));
  // R6
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !dq_valid |-> (dq_data == '0 && dq_mask == '0));
  // R4
  beat_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(dq_valid) |=> dq_valid && $stable(dq_data)));
endmodule

// File: rtl/ddrw_launch_sched.sv
module ddrw_launch_sched
  import ddrw_pkg::*;
#(
  parameter int DW         = 16,
  parameter int MW         = DW / 8,
  parameter int Q_DEPTH    = 2,
  parameter int SKEW_TICKS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [BEATS*DW-1:0] wr_data,
  input  logic [BEATS*MW-1:0] wr_mask,
  input  logic                cfg_rdimm,
  input  logic [WDD_W-1:0]    cfg_wdelay,
  output logic                cmd_go,
  output logic                dqs_en,
  output logic                dq_valid,
  output logic [DW-1:0]       dq_data,
  output logic [MW-1:0]       dq_mask,
  output logic [PH_W-1:0]     out_phase,
  output logic                dqs_win_ok
);
  localparam int QW = BEATS * (DW + MW);

  logic             q_valid, start, busy;
  logic [QW-1:0]    q_data;
  logic [CNT_W-1:0] cnt, off;
  logic [PH_W-1:0]  phase;

  ddrw_cmd_fifo #(.W(QW), .DEPTH(Q_DEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .in_valid(wr_valid), .in_ready(wr_ready), .in_data({wr_mask, wr_data}),
    .pop(start), .out_valid(q_valid), .out_data(q_data)
  );

  ddrw_seq #(.SKEW_TICKS(SKEW_TICKS)) u_seq (
    .clk(clk), .rst(rst), .q_valid(q_valid),
    .cfg_rdimm(cfg_rdimm), .cfg_wdelay(cfg_wdelay),
    .start(start), .busy(busy), .cnt(cnt), .off(off),
    .phase(phase), .win_ok(dqs_win_ok)
  );

  ddrw_out_stage #(.DW(DW), .MW(MW)) u_out (
    .clk(clk), .rst(rst), .start(start),
    .in_data(q_data[BEATS*DW-1:0]), .in_mask(q_data[QW-1:BEATS*DW]),
    .busy(busy), .cnt(cnt), .off(off), .phase(phase),
    .cmd_go(cmd_go), .dqs_en(dqs_en), .dq_valid(dq_valid),
    .dq_data(dq_data), .dq_mask(dq_mask), .out_phase(out_phase)
  );

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (dqs_en && !cmd_go) |=> !cmd_go || !$past(busy) || !$stable(busy) || !dqs_en);
endmodule

// File: tb/tb_ddrw_launch_sched.sv
module tb_ddrw_launch_sched;
  localparam int DW = 16;
  localparam int MW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [4*DW-1:0] wr_data = '0;
  logic [4*MW-1:0] wr_mask = '0;
  logic cfg_rdimm = 1'b0;
  logic [2:0] cfg_wdelay = 3'd0;
  logic cmd_go, dqs_en, dq_valid, dqs_win_ok;
  logic [DW-1:0] dq_data;
  logic [MW-1:0] dq_mask;
  logic [1:0] out_phase;

  ddrw_launch_sched #(.DW(DW), .MW(MW)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_mask(wr_mask),
    .cfg_rdimm(cfg_rdimm), .cfg_wdelay(cfg_wdelay),
    .cmd_go(cmd_go), .dqs_en(dqs_en), .dq_valid(dq_valid),
    .dq_data(dq_data), .dq_mask(dq_mask), .out_phase(out_phase),
    .dqs_win_ok(dqs_win_ok)
  );

  always #2 clk = ~clk;   // 250 MHz

  int n_cmp = 0, n_bad = 0, tick = 0;
  int n_go = 0, n_push = 0, r6_bad = 0, ready_low = 0;
  int go_t[64], go_ph[64], dqs_rise[64], dqs_fall[64];
  int dv_first[64], dv_ph[64], dv_cnt[64];
  logic [DW-1:0] cap_d[64][8];
  logic [MW-1:0] cap_m[64][8];
  int e_rd[64], e_wd[64];
  logic [4*DW-1:0] e_data[64];
  logic [4*MW-1:0] e_mask[64];
  logic dqs_prev = 1'b0;

  always @(posedge clk) tick++;

  always @(negedge clk) begin
    int cur;
    if (!rst) begin
      if (cmd_go && n_go < 64) begin
        go_t[n_go] = tick; go_ph[n_go] = int'(out_phase); n_go++;
      end
      cur = n_go - 1;
      if (cur >= 0 && cur < 64) begin
        if (dqs_en && !dqs_prev) dqs_rise[cur] = tick;
        if (!dqs_en && dqs_prev) dqs_fall[cur] = tick;
        if (dq_valid) begin
          if (dv_cnt[cur] == 0) begin
            dv_first[cur] = tick; dv_ph[cur] = int'(out_phase);
          end
          if (dv_cnt[cur] < 8) begin
            cap_d[cur][dv_cnt[cur]] = dq_data;
            cap_m[cur][dv_cnt[cur]] = dq_mask;
          end
          dv_cnt[cur]++;
        end
      end
      if (!dq_valid && (dq_data != '0 || dq_mask != '0)) r6_bad++;
      if (!wr_ready) ready_low++;
      dqs_prev = dqs_en;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic rd, input logic [2:0] w);
    @(negedge clk);
    cfg_rdimm = rd; cfg_wdelay = w;
  endtask

  task automatic push(input logic [4*DW-1:0] d, input logic [4*MW-1:0] m);
    e_rd[n_push] = int'(cfg_rdimm); e_wd[n_push] = int'(cfg_wdelay);
    e_data[n_push] = d; e_mask[n_push] = m; n_push++;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_mask = m;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    while (n_go < n_push) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  function automatic int exp_off(input int rd, input int w);
    return 4 * (1 + rd) + w;
  endfunction

  function automatic int exp_win(input int w);
    return ((w + 3) >= 3 && (w + 3) <= 5) ? 1 : 0;
  endfunction

  task automatic check_burst(input int i);
    int d;
    d = exp_off(e_rd[i], e_wd[i]);
    chk("R2 launch phase", go_ph[i], 0);
    chk("R3 first beat offset", dv_first[i] - go_t[i], d);
    chk("R3 first beat phase", dv_ph[i], d % 4);
    chk("R5 preamble", dv_first[i] - dqs_rise[i], 4);
    chk("R5 postamble", dqs_fall[i] - dv_first[i], 10);
    chk("R4 beat ticks", dv_cnt[i], 8);
    for (int k = 0; k < 8; k++) begin
      chk("R4 data beat order", cap_d[i][k], e_data[i][(k/2)*DW +: DW]);
      chk("R4 mask beat order", cap_m[i][k], e_mask[i][(k/2)*MW +: MW]);
    end
  endtask

  function automatic logic [4*DW-1:0] rnd_data();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed, base, lo0, rr, ww;
    seed = $urandom(32'd20240611);
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: during reset
    chk("R1 cmd_go", cmd_go, 0);
    chk("R1 dqs_en", dqs_en, 0);
    chk("R1 dq_valid", dq_valid, 0);
    chk("R1 dq_data", dq_data, 0);
    chk("R1 dq_mask", dq_mask, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 win flag", dqs_win_ok, 0);
    @(posedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", int'(dqs_en) + int'(dq_valid) + int'(cmd_go), 0);

    // R3 R4 R5 R9: full sweep of delay values, flag off and on
    for (int rd = 0; rd < 2; rd++) begin
      for (int w = 0; w < 8; w++) begin
        set_cfg(rd[0], w[2:0]);
        @(negedge clk);
        chk("R9 window flag", dqs_win_ok, exp_win(w));
        base = n_push;
        push(64'h4444_3333_2222_1111 + 64'(w), 8'b11_10_01_00);
        drain();
        check_burst(base);
      end
    end

    // R8: change configuration right after launch
    set_cfg(1'b0, 3'd2);
    base = n_push;
    push(64'hDEAD_BEEF_CAFE_F00D, 8'h93);
    while (n_go <= base) @(negedge clk);
    cfg_rdimm = 1'b1; cfg_wdelay = 3'd7;
    drain();
    check_burst(base);

    // R7 R10: four back-to-back commands fill the queue
    set_cfg(1'b1, 3'd7);
    lo0 = ready_low;
    base = n_push;
    for (int j = 0; j < 4; j++) push(rnd_data(), 8'($urandom()));
    drain();
    chk("R7 ready back-pressure seen", (ready_low > lo0) ? 1 : 0, 1);
    chk("R7 bursts launched", n_go - base, 4);
    for (int j = 0; j < 4; j++) check_burst(base + j);
    for (int j = 0; j < 3; j++)
      chk("R10 no overlap", (go_t[base+j+1] >= dqs_fall[base+j]) ? 1 : 0, 1);

    // random bursts, pairs share a configuration
    for (int j = 0; j < 8; j++) begin
      rr = int'($urandom() % 2); ww = int'($urandom() % 8);
      set_cfg(rr[0], ww[2:0]);
      base = n_push;
      push(rnd_data(), 8'($urandom()));
      if ($urandom() % 2 == 1) push(rnd_data(), 8'($urandom()));
      drain();
      for (int k = base; k < n_push; k++) check_burst(k);
      @(negedge clk);
      chk("R9 window flag random", dqs_win_ok, exp_win(ww));
    end

    chk("R6 idle bus zero", r6_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule